// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder Model

This block models the control side of a 16-bit extended-data-out dynamic RAM as it would appear behind a memory controller. The row strobe, the two byte-lane column strobes, the write enable and the output enable are sampled on a fast system clock. The block works out from the order of their edges what kind of cycle is running. If either column strobe is already low when the row strobe falls, the cycle is a refresh driven by an internal row counter. Otherwise the row address is latched and later column strobes select a column for byte or word reads and writes. A row strobe period with no column strobe at all is a refresh of the latched row.

Read data is registered per byte lane and keeps being driven after the column strobe rises. This is the extended-data-out behaviour. A lane stops driving only when output enable rises, the row strobe rises, or write enable goes low. Each lane has its own output enable, so an external tristate stage can build the bidirectional bus.

The block is also a protocol checker for a controller under test. A sticky error flag records an address that moves inside the hold window after a strobe edge, and a row strobe held low for too many samples. The storage array keeps only a few low row and column bits, so the model stays small in simulation.

Top module: `edo_dram_model`

## Requirements
- R1: After reset both lane enables `dq_oe` are 0, `proto_err` is 0 and `refresh_row` is 0.
- R2: While `ras_n` is high, both lane enables are 0 one sample later, and write strobes and data are ignored. No stored word changes.
- R3: A row strobe period in which neither column strobe goes low leaves both lanes undriven throughout.
- R4: If `lcas_n` or `ucas_n` is low in the sample where `ras_n` falls, `refresh_row` increments by one modulo 512, visible one sample later. No lane is driven and no write happens during that row strobe period.
- R5: In a normal access with `we_n` high and `oe_n` low, a low `lcas_n` drives stored bits 7:0 with `dq_oe[0]`=1, and a low `ucas_n` drives bits 15:8 with `dq_oe[1]`=1, one sample after the strobe sample. A lane whose strobe was never low stays undriven.
- R6: In a normal access with `we_n` low, each lane whose column strobe is low stores its `dq_in` byte at the latched row and column. The other lane's byte keeps its old value.
- R7: A driving lane keeps its data and enable after its column strobe rises, as long as `ras_n` stays low, `oe_n` stays low and `we_n` stays high.
- R8: A driving lane turns off one sample after `oe_n` is high, `ras_n` is high, or `we_n` is low.
- R9: `addr` must hold its value for HOLD_CYC (default 2) samples after the row-fall sample of a normal access and after each column-fall sample. A change inside that window sets the sticky `proto_err` one sample later.
- R10: `ras_n` may stay low for RAS_MAX_CYC (default 64) consecutive samples. The next low sample sets `proto_err` one sample later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for bits 7:0, active low |
| ucas_n | input | 1 | Column strobe for bits 15:8, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row and column address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data; a lane reads 0 when not enabled |
| dq_oe | output | 2 | Per-lane output enables (bit 0: low byte) |
| refresh_row | output | 9 | Internal refresh row counter |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The hardest states to reach are the edge-order corners. One is a column strobe that is already low when the row strobe falls, because only that ordering turns an otherwise ordinary cycle into a counter refresh. The stimulus parks both column strobes low during standby before dropping the row strobe, with write enable low and junk data applied. A later read then shows the array was not touched. The refresh counter is walked through a full 512-step wrap. The hold-time corner is forced with deliberate address slips one sample after a row fall and one sample after a column fall. The row-strobe limit is probed at exactly the allowed sample count and at one more.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE    = 2'd0,
    KIND_ACCESS  = 2'd1,
    KIND_REFRESH = 2'd2
  } row_kind_e;

  // flat index into the folded storage: row slot major, column slot minor
  function automatic int unsigned cell_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned n_rows,
                                             input int unsigned n_cols);
    return (row % n_rows) * n_cols + (col % n_cols);
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned modulus);
    return (v + 1) % modulus;
  endfunction

endpackage

// File: rtl/edo_strobe_seq.sv
module edo_strobe_seq #(
  parameter int ADDR_W      = 9,
  parameter int HOLD_CYC    = 2,
  parameter int RAS_MAX_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              access_now,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_eff,
  output logic              cbr_evt,
  output logic              ras_only_evt,
  output logic              proto_err
);
  import edo_pkg::*;

  localparam int WIN_W = $clog2(HOLD_CYC + 1);
  localparam int RCNT_W = $clog2(RAS_MAX_CYC + 2);

  logic ras_p, lcas_p, ucas_p;
  logic ras_fall, ras_rise, cas_fall;
  row_kind_e kind_q;
  logic [ADDR_W-1:0] col_q;
  logic cas_seen;
  logic [WIN_W-1:0] win_cnt;
  logic [ADDR_W-1:0] win_ref;
  logic win_load, addr_slip;
  logic [RCNT_W-1:0] ras_cnt;
  logic ras_over;

  // edge events relative to the previous sample
  assign ras_fall = ras_p & ~ras_n;
  assign ras_rise = ~ras_p & ras_n;
  assign cas_fall = (lcas_p & ~lcas_n) | (ucas_p & ~ucas_n);
  assign cbr_evt  = ras_fall & (~lcas_n | ~ucas_n);

  assign access_now   = (kind_q == KIND_ACCESS) && !ras_n;
  assign ras_only_evt = ras_rise && (kind_q == KIND_ACCESS) && !cas_seen;
  assign col_eff      = (cas_fall && access_now) ? addr : col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p  <= 1'b1;
      lcas_p <= 1'b1;
      ucas_p <= 1'b1;
    end else begin
      ras_p  <= ras_n;
      lcas_p <= lcas_n;
      ucas_p <= ucas_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= KIND_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      cas_seen <= 1'b0;
    end else begin
      if (ras_fall) begin
        kind_q   <= cbr_evt ? KIND_REFRESH : KIND_ACCESS;
        cas_seen <= 1'b0;
        if (!cbr_evt) row_q <= addr;
      end else if (ras_n) begin
        kind_q <= KIND_IDLE;
      end
      if (cas_fall && access_now) begin
        col_q    <= addr;
        cas_seen <= 1'b1;
      end
    end
  end

  // address hold window after row fall (normal access) and column fall
  assign win_load  = (ras_fall && !cbr_evt) || (cas_fall && access_now);
  assign addr_slip = (win_cnt != '0) && (addr != win_ref) && !win_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      win_ref <= '0;
    end else if (win_load) begin
      win_cnt <= WIN_W'(HOLD_CYC);
      win_ref <= addr;
    end else if (win_cnt != '0) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

  // consecutive low samples of the row strobe
  assign ras_over = !ras_n && (ras_cnt == RCNT_W'(RAS_MAX_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_cnt <= '0;
    end else if (ras_n) begin
      ras_cnt <= '0;
    end else if (ras_cnt != RCNT_W'(RAS_MAX_CYC)) begin
      ras_cnt <= ras_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= proto_err | addr_slip | ras_over;
  end

  a_r9_slip_flags: assert property (@(posedge clk) disable iff (!rst_n)
    addr_slip |=> proto_err);

  a_r10_ras_limit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ras_over |=> proto_err);

  a_r4_refresh_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_evt |=> !access_now);

endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int REF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [REF_W-1:0] ref_row
);
  import edo_pkg::*;

  localparam int REF_MOD = 1 << REF_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_row <= '0;
    else if (bump) ref_row <= REF_W'(wrap_inc(int'(ref_row), REF_MOD));
  end

endmodule

// File: rtl/edo_lane_store.sv
module edo_lane_store #(
  parameter int ADDR_W   = 9,
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int ROW_KEEP = 2,
  parameter int COL_KEEP = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     access_now,
  input  logic [LANES-1:0]         lane_low,
  input  logic                     we_n,
  input  logic                     oe_n,
  input  logic                     ras_n,
  input  logic [ADDR_W-1:0]        row,
  input  logic [ADDR_W-1:0]        col,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic [LANES-1:0]         dq_oe
);
  import edo_pkg::*;

  localparam int N_ROWS = 1 << ROW_KEEP;
  localparam int N_COLS = 1 << COL_KEEP;
  localparam int DEPTH  = N_ROWS * N_COLS;
  localparam int IDX_W  = ROW_KEEP + COL_KEEP;

  logic [IDX_W-1:0] idx;
  logic             release_all;

  assign idx = IDX_W'(cell_index(int'(row), int'(col), N_ROWS, N_COLS));
  assign release_all = oe_n | ras_n | ~we_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] hold_q;
    logic              drv_q;
    logic              wr_hit, rd_hit;

    assign wr_hit = access_now && lane_low[g] && !we_n;
    assign rd_hit = access_now && lane_low[g] && we_n && !oe_n;

    always_ff @(posedge clk) begin
      if (wr_hit) cells[idx] <= dq_in[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        drv_q  <= 1'b0;
        hold_q <= '0;
      end else if (rd_hit) begin
        drv_q  <= 1'b1;
        hold_q <= cells[idx];
      end else if (release_all) begin
        drv_q <= 1'b0;
      end
    end

    assign dq_oe[g] = drv_q;
    assign dq_out[g*LANE_W +: LANE_W] = drv_q ? hold_q : '0;
  end

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
  parameter int ADDR_W      = 9,
  parameter int LANE_W      = 8,
  parameter int ROW_KEEP    = 2,
  parameter int COL_KEEP    = 3,
  parameter int HOLD_CYC    = 2,
  parameter int RAS_MAX_CYC = 64,
  parameter int REF_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] dq_out,
  output logic [1:0]        dq_oe,
  output logic [REF_W-1:0]  refresh_row,
  output logic              proto_err
);
  localparam int LANES = 2;

  logic              access_now;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] col_eff;
  logic              cbr_evt;
  logic              ras_only_evt;
  logic [LANES-1:0]  lane_low;

  assign lane_low = {~ucas_n, ~lcas_n};

  edo_strobe_seq #(
    .ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC), .RAS_MAX_CYC(RAS_MAX_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .addr(addr), .access_now(access_now), .row_q(row_q), .col_eff(col_eff),
    .cbr_evt(cbr_evt), .ras_only_evt(ras_only_evt), .proto_err(proto_err)
  );

  edo_refresh_ctr #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .bump(cbr_evt), .ref_row(refresh_row)
  );

  edo_lane_store #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W),
    .ROW_KEEP(ROW_KEEP), .COL_KEEP(COL_KEEP)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .access_now(access_now), .lane_low(lane_low),
    .we_n(we_n), .oe_n(oe_n), .ras_n(ras_n), .row(row_q), .col(col_eff),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |=> dq_oe == 2'b00);

  a_r3_ras_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ras_only_evt |-> dq_oe == 2'b00);

  a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_evt |=> refresh_row == REF_W'($past(refresh_row) + 1'b1));

  a_r5_low_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe[0]) |-> $past(!lcas_n && we_n && !oe_n));

  a_r5_high_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe[1]) |-> $past(!ucas_n && we_n && !oe_n));

  a_r8_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> dq_oe == 2'b00);

endmodule

// File: tb/edo_dram_model_tb.sv
module edo_dram_model_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [8:0]  refresh_row;
  logic        proto_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ref_exp = 0;
  bit done = 0;
  logic [15:0] model [32];

  typedef struct {
    int          at;
    logic [1:0]  oe;
    logic [15:0] data;
    string       tag;
  } item_t;
  item_t sb[$];

  edo_dram_model u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .refresh_row(refresh_row), .proto_err(proto_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // storage folds to 4 row slots x 8 column slots
  function automatic int slot(input int row, input int col);
    return ((row & 3) << 3) | (col & 7);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_bus(input string tag, input logic [1:0] oe, input logic [15:0] d);
    item_t it;
    it.at = cyc + 1;
    it.oe = oe;
    it.data = d;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare expected bus items in the sample they target
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic [15:0] m;
      it = sb.pop_front();
      m = {{8{it.oe[1]}}, {8{it.oe[0]}}};
      checks++;
      if (it.at != cyc || dq_oe !== it.oe || (dq_out & m) !== (it.data & m)) begin
        errors++;
        $display("FAIL %s actual oe=%b data=%h expected oe=%b data=%h",
                 it.tag, dq_oe, dq_out, it.oe, it.data);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
    step();
    step();
    rst_n = 1'b1;
    step();
    ref_exp = 0;
  endtask

  task automatic open_row(input int row);
    ras_n = 1; lcas_n = 1; ucas_n = 1; addr = 9'(row);
    step();
    ras_n = 0;
    step();
    step();
    step();
  endtask

  task automatic close_row();
    lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
    step();
    ras_n = 1;
    step();
  endtask

  task automatic write_cycle(input int row, input int col, input logic [1:0] lanes,
                             input logic [15:0] d);
    int s;
    open_row(row);
    addr = 9'(col);
    step();
    lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; we_n = 0; dq_in = d;
    expect_bus("R6 no drive while writing", 2'b00, 16'h0);
    step();
    step();
    step();
    s = slot(row, col);
    if (lanes[0]) model[s][7:0]  = d[7:0];
    if (lanes[1]) model[s][15:8] = d[15:8];
    close_row();
  endtask

  // rel: 0 = OE high, 1 = RAS high, 2 = WE low
  task automatic read_cycle(input int row, input int col, input logic [1:0] lanes,
                            input int rel, input string tag);
    logic [15:0] e;
    e = model[slot(row, col)];
    open_row(row);
    addr = 9'(col); oe_n = 0; we_n = 1;
    step();
    lcas_n = ~lanes[0]; ucas_n = ~lanes[1];
    expect_bus(tag, lanes, e);
    step();
    expect_bus(tag, lanes, e);
    step();
    lcas_n = 1; ucas_n = 1;
    expect_bus("R7 data held after CAS rise", lanes, e);
    step();
    expect_bus("R7 data held after CAS rise", lanes, e);
    step();
    case (rel)
      0: oe_n = 1;
      1: ras_n = 1;
      default: we_n = 0;
    endcase
    expect_bus("R8 lane released", 2'b00, 16'h0);
    step();
    close_row();
  endtask

  task automatic cbr_cycle(input bit verify);
    ras_n = 1; lcas_n = 0; ucas_n = 0; we_n = 0; oe_n = 0; dq_in = 16'hDEAD; addr = 9'h1;
    step();
    ras_n = 0; addr = 9'h0A;
    if (verify) expect_bus("R4 no drive in refresh", 2'b00, 16'h0);
    step();
    ref_exp = (ref_exp + 1) % 512;
    if (verify) check("R4 refresh counter step", 32'(refresh_row), 32'(ref_exp));
    step();
    lcas_n = 1; ucas_n = 1; ras_n = 1; we_n = 1; oe_n = 1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 lanes off after reset", 32'(dq_oe), 32'h0);
    check("R1 error clear after reset", 32'(proto_err), 32'h0);
    check("R1 counter zero after reset", 32'(refresh_row), 32'h0);

    // word and byte traffic
    write_cycle(1, 2, 2'b11, 16'hA5C3);
    read_cycle(1, 2, 2'b11, 0, "R5 word read");
    write_cycle(1, 2, 2'b01, 16'h1177);
    read_cycle(1, 2, 2'b11, 1, "R6 lower byte write kept upper");
    write_cycle(3, 5, 2'b11, 16'h3C4B);
    write_cycle(3, 5, 2'b10, 16'h9922);
    read_cycle(3, 5, 2'b10, 2, "R5 upper lane only");
    read_cycle(3, 5, 2'b01, 0, "R5 lower lane only");
    write_cycle(2, 7, 2'b11, 16'h0F0F);

    // standby: strobes other than RAS must not write or drive
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 0; oe_n = 0; dq_in = 16'hFFFF; addr = 9'h2;
    expect_bus("R2 standby undriven", 2'b00, 16'h0);
    step();
    lcas_n = 0;
    expect_bus("R2 standby undriven", 2'b00, 16'h0);
    step();
    lcas_n = 1; we_n = 1; oe_n = 1;
    step();
    read_cycle(1, 2, 2'b11, 0, "R2 standby left storage alone");

    // RAS-only refresh
    oe_n = 0;
    ras_n = 0; addr = 9'h3;
    for (int k = 0; k < 4; k++) begin
      expect_bus("R3 ras-only undriven", 2'b00, 16'h0);
      step();
    end
    ras_n = 1; oe_n = 1;
    expect_bus("R3 ras-only undriven", 2'b00, 16'h0);
    step();

    // CAS-before-RAS refresh with write strobes active
    cbr_cycle(1);
    cbr_cycle(1);
    cbr_cycle(1);
    read_cycle(3, 5, 2'b11, 0, "R4 refresh did not write");
    read_cycle(2, 7, 2'b11, 1, "R4 refresh did not write");
    check("R9 no false alarm on legal traffic", 32'(proto_err), 32'h0);
    for (int k = 3; k < 511; k++) cbr_cycle(0);
    check("R4 counter at 511", 32'(refresh_row), 32'd511);
    cbr_cycle(1);
    check("R4 counter wrapped to 0", 32'(refresh_row), 32'h0);

    // address slip after row fall
    ras_n = 1; addr = 9'h4;
    step();
    ras_n = 0;
    step();
    check("R9 no error before slip", 32'(proto_err), 32'h0);
    addr = 9'h5;
    step();
    check("R9 row hold slip flagged", 32'(proto_err), 32'h1);
    ras_n = 1;
    step();
    check("R9 flag is sticky", 32'(proto_err), 32'h1);
    do_reset();
    check("R1 reset clears flag", 32'(proto_err), 32'h0);

    // address slip after column fall
    open_row(1);
    addr = 9'h6;
    step();
    lcas_n = 0;
    step();
    check("R9 no error at column fall", 32'(proto_err), 32'h0);
    addr = 9'h7;
    step();
    check("R9 column hold slip flagged", 32'(proto_err), 32'h1);
    close_row();
    do_reset();

    // RAS low limit
    ras_n = 0; addr = 9'h8;
    for (int k = 0; k < 64; k++) step();
    ras_n = 1;
    step();
    check("R10 limit not exceeded", 32'(proto_err), 32'h0);
    ras_n = 0;
    for (int k = 0; k < 65; k++) step();
    check("R10 limit exceeded flagged", 32'(proto_err), 32'h1);
    ras_n = 1;
    step();
    step();

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard not drained actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule